// File: doc/BRIEF.md
# Buffered PWM with Synchronized Load

This block produces one pulse-width-modulated output from a free-running 16-bit time base. Software sets the period and the duty value one byte at a time through a small register write port. These bytes land in holding registers, and the waveform never sees them directly. The output keeps running on the values in a separate set of active registers.

To make new values take effect, software writes the load-request bit. On the first period-reset event after that, all four holding bytes are copied into the active registers at the same clock edge. Frequency and duty can therefore change together, and no mixed or half-written waveform appears. Software may rebuild the holding bytes across many writes, with any intermediate values, and only then arm the load. Arming again when nothing has changed is harmless.

Two small state machines do the work. The load sequencer has the states `LD_IDLE` and `LD_ARMED`. Its transitions are:
- *arm*: `LD_IDLE` to `LD_ARMED`, taken when the load request is written.
- *commit*: `LD_ARMED` to `LD_IDLE`, taken at a period reset when no new request arrives in the same cycle.
- *commit-and-rearm*: `LD_ARMED` to `LD_ARMED`, taken at a period reset that coincides with a new request.

The output phase machine has the states `PH_LOW` and `PH_HIGH`. It takes *rise* when the next counter value is below the next active duty and *fall* otherwise.

Top module: `pwm_sync_load`

## Requirements
- R1: The address map is as follows. Address 0 holds the period low byte, 1 the period high byte, 2 the duty low byte, 3 the duty high byte, and 4 is control. Reading addresses 0 to 3 returns the last byte written there. Reading address 4 returns the load-pending flag in bit 0 and zeros elsewhere. Addresses 5 to 7 read as zero, and writes to them change nothing.
- R2: Writes to holding registers do not change the output waveform until a load has been committed.
- R3: Writing control with bit 0 = 1 arms a load. The pending flag then reads 1 until the commit. Writing control with bit 0 = 0 has no effect.
- R4: The commit happens at the first period-reset event after arming. All four bytes move into the active registers at one clock edge, and the pending flag reads 0 from that edge on.
- R5: The counter counts from 0 up to the active period P. The period-reset event is the cycle where the counter equals P, and the counter returns to 0 on the next clock. One output period is therefore P+1 cycles.
- R6: The output is high while the counter is below the active duty D, so each period has D high cycles. D = 0 gives a constant low output, and D > P gives a constant high output.
- R7: Re-arming repeatedly with unchanged holding values leaves the waveform unchanged.
- R8: Holding writes made while a load is pending are included in the commit if they land before the period-reset event.
- R9: A request written in the cycle of a period-reset event is treated as follows:
  - If the sequencer was idle, it arms and waits for the next event.
  - If a load was already pending, that load commits and the sequencer stays armed for the next event.
- R10: After synchronous reset, all holding and active registers read 0, the counter is 0, no load is pending and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| pwm_o | output | 1 | PWM output |

## Verification
The bench rewrites the holding bytes, including deliberately bad intermediate values, without arming. A design that passed holding bytes straight through would show these as a glitching duty. The bench also re-arms every few cycles with nothing changed, which catches designs that restart the counter or drop the output whenever a load is requested. It arms exactly on the period-reset cycle from both the idle and the pending state, so a design that commits one period early, or loses the second request, produces the wrong duty or the wrong pending flag. Duty 0, duty equal to the period, duty above the period and a period spanning both bytes expose off-by-one compares and a missing high byte.

// File: rtl/pwm_sl_pkg.sv
package pwm_sl_pkg;

    typedef enum logic {
        LD_IDLE  = 1'b0,
        LD_ARMED = 1'b1
    } ld_state_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } ph_state_e;

endpackage

// File: rtl/pwm_sl_regs.sv
module pwm_sl_regs #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              pending,
    output logic [CNT_W-1:0]  hold_per,
    output logic [CNT_W-1:0]  hold_dut,
    output logic              arm_req,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NB = CNT_W / DATA_W;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2 * NB);

    // one byte lane per generate step: period bytes first, duty bytes after
    for (genvar b = 0; b < NB; b++) begin : g_byte
        localparam logic [ADDR_W-1:0] PER_A = ADDR_W'(b);
        localparam logic [ADDR_W-1:0] DUT_A = ADDR_W'(NB + b);

        always_ff @(posedge clk) begin
            if (rst) begin
                hold_per[b*DATA_W +: DATA_W] <= '0;
            end else if (wr_en && wr_addr == PER_A) begin
                hold_per[b*DATA_W +: DATA_W] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                hold_dut[b*DATA_W +: DATA_W] <= '0;
            end else if (wr_en && wr_addr == DUT_A) begin
                hold_dut[b*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end

    // a control write with bit 0 set is a one-cycle load request
    always_comb begin
        arm_req = wr_en && (wr_addr == CTRL_ADDR) && wr_data[0];
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NB; b++) begin
            if (rd_addr == ADDR_W'(b)) begin
                rd_data = hold_per[b*DATA_W +: DATA_W];
            end
            if (rd_addr == ADDR_W'(NB + b)) begin
                rd_data = hold_dut[b*DATA_W +: DATA_W];
            end
        end
        if (rd_addr == CTRL_ADDR) begin
            rd_data = {{(DATA_W-1){1'b0}}, pending};
        end
    end

    AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr > CTRL_ADDR) |=> ($stable(hold_per) && $stable(hold_dut))); // R1

    AST_CTRL_WRITE_KEEPS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == CTRL_ADDR) |=> ($stable(hold_per) && $stable(hold_dut))); // R3

endmodule

// File: rtl/pwm_sl_loadctl.sv
module pwm_sl_loadctl
    import pwm_sl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_req,
    input  logic             period_evt,
    input  logic [CNT_W-1:0] hold_per,
    input  logic [CNT_W-1:0] hold_dut,
    output logic [CNT_W-1:0] act_per,
    output logic [CNT_W-1:0] act_dut,
    output logic [CNT_W-1:0] dut_nxt,
    output logic             pending
);
    ld_state_e state_q, state_d;
    logic      commit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:  state_d = arm_req ? LD_ARMED : LD_IDLE;             // arm
            LD_ARMED: state_d = (period_evt && !arm_req) ? LD_IDLE         // commit
                                                         : LD_ARMED;       // wait / commit-and-rearm
        endcase
    end

    always_comb begin
        commit  = (state_q == LD_ARMED) && period_evt;
        pending = (state_q == LD_ARMED);
        dut_nxt = commit ? hold_dut : act_dut;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_per <= '0;
            act_dut <= '0;
        end else if (commit) begin
            act_per <= hold_per;
            act_dut <= hold_dut;
        end
    end

    AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !(pending && period_evt) |=> ($stable(act_per) && $stable(act_dut))); // R2

    AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pending && !period_evt) |=> pending); // R3

    AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (rst)
        (pending && period_evt) |=> (act_per == $past(hold_per) && act_dut == $past(hold_dut))); // R4

    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (pending && period_evt && !arm_req) |=> !pending); // R4

    AST_REARM_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        (arm_req && period_evt) |=> pending); // R9

endmodule

// File: rtl/pwm_sl_timebase.sv
module pwm_sl_timebase
    import pwm_sl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] act_per,
    input  logic [CNT_W-1:0] act_dut,
    input  logic [CNT_W-1:0] dut_nxt,
    output logic             period_evt,
    output logic             pwm_o
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    ph_state_e        ph_q, ph_d;

    always_comb begin
        period_evt = (cnt_q == act_per);
        cnt_d      = period_evt ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // output phase: rise while the coming count is under the coming duty
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_LOW:  ph_d = (cnt_d < dut_nxt) ? PH_HIGH : PH_LOW;   // rise
            PH_HIGH: ph_d = (cnt_d < dut_nxt) ? PH_HIGH : PH_LOW;   // fall
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_LOW;
        end else begin
            ph_q <= ph_d;
        end
    end

    always_comb begin
        pwm_o = (ph_q == PH_HIGH);
    end

    AST_COUNT_WRAPS: assert property (@(posedge clk) disable iff (rst)
        period_evt |=> (cnt_q == '0)); // R5

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= act_per); // R5

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
        (act_dut == '0) |-> !pwm_o); // R6

    AST_OVER_DUTY_HIGH: assert property (@(posedge clk) disable iff (rst)
        (act_dut > act_per) |-> pwm_o); // R6

endmodule

// File: rtl/pwm_sync_load.sv
module pwm_sync_load #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_o
);
    logic [CNT_W-1:0] hold_per, hold_dut;
    logic [CNT_W-1:0] act_per, act_dut, dut_nxt;
    logic             arm_req, pending, period_evt;

    pwm_sl_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .pending  (pending),
        .hold_per (hold_per),
        .hold_dut (hold_dut),
        .arm_req  (arm_req),
        .rd_data  (rd_data)
    );

    pwm_sl_loadctl #(.CNT_W(CNT_W)) u_load (
        .clk        (clk),
        .rst        (rst),
        .arm_req    (arm_req),
        .period_evt (period_evt),
        .hold_per   (hold_per),
        .hold_dut   (hold_dut),
        .act_per    (act_per),
        .act_dut    (act_dut),
        .dut_nxt    (dut_nxt),
        .pending    (pending)
    );

    pwm_sl_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk        (clk),
        .rst        (rst),
        .act_per    (act_per),
        .act_dut    (act_dut),
        .dut_nxt    (dut_nxt),
        .period_evt (period_evt),
        .pwm_o      (pwm_o)
    );

endmodule

// File: tb/pwm_sync_load_test.sv
module pwm_sync_load_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [2:0] rd_addr;
    logic [7:0] rd_data;
    logic       pwm_o;

    always #4 clk = ~clk;

    pwm_sync_load uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string tag     = "R10";
    bit    exp_q[$];

    // spec model: driver-side expectation generator
    logic [15:0] m_cnt, m_aper, m_adut, m_hper, m_hdut;
    bit          m_armed;

    always @(posedge clk) begin
        bit evt, setr, xfer;
        if (rst) begin
            m_cnt = 0; m_aper = 0; m_adut = 0; m_hper = 0; m_hdut = 0; m_armed = 0;
            exp_q.push_back(1'b0);
        end else begin
            evt  = (m_cnt == m_aper);
            setr = wr_en && wr_addr == 3'd4 && wr_data[0];
            xfer = m_armed && evt;
            if (xfer) begin
                m_aper = m_hper;
                m_adut = m_hdut;
            end
            m_armed = setr || (m_armed && !evt);
            m_cnt   = evt ? 16'd0 : m_cnt + 16'd1;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_hper[7:0]  = wr_data;
                    3'd1: m_hper[15:8] = wr_data;
                    3'd2: m_hdut[7:0]  = wr_data;
                    3'd3: m_hdut[15:8] = wr_data;
                    default: ;
                endcase
            end
            exp_q.push_back(m_adut > m_cnt);
        end
    end

    task automatic check(string t, logic [15:0] got, logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", t, got, exp);
        end
    endtask

    // monitor: pops one expectation per cycle
    always @(negedge clk) begin
        bit e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check({tag, " waveform"}, {15'd0, pwm_o}, {15'd0, e});
        end
    end

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic arm_now();
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string t, logic [2:0] a, logic [7:0] exp);
        rd_addr = a;
        #1;
        check(t, {8'd0, rd_data}, {8'd0, exp});
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(string t, int eh, int ep);
        logic last;
        bit   r;
        int   g = 0;
        int   hi = 0;
        int   per = 0;
        last = pwm_o;
        do begin
            @(negedge clk);
            r = (last == 1'b0 && pwm_o == 1'b1);
            last = pwm_o;
            g++;
        end while (!r && g < 5000);
        do begin
            hi += int'(pwm_o);
            per++;
            @(negedge clk);
            r = (last == 1'b0 && pwm_o == 1'b1);
            last = pwm_o;
        end while (!r && per < 5000);
        check({t, " high count"}, 16'(hi), 16'(eh));
        check({t, " period"}, 16'(per), 16'(ep));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        tag = "R10";
        for (int a = 0; a < 5; a++) rd_chk("R10 readback", 3'(a), 8'h00);
        check("R10 output low", {15'd0, pwm_o}, 16'd0);

        // R1: map, readback, unmapped addresses
        tag = "R1";
        wr(0, 8'd9); wr(1, 8'd0); wr(2, 8'd4); wr(3, 8'd0);
        rd_chk("R1 period lo", 0, 8'd9);
        rd_chk("R1 duty lo", 2, 8'd4);
        wr(5, 8'hFF); wr(7, 8'hAA);
        rd_chk("R1 unmapped read", 5, 8'h00);
        rd_chk("R1 unmapped read", 7, 8'h00);
        rd_chk("R1 hold after unmapped", 0, 8'd9);
        rd_chk("R1 hold after unmapped", 3, 8'd0);

        // R2: no effect before a load
        tag = "R2";
        idle(20);
        check("R2 output still low", {15'd0, pwm_o}, 16'd0);

        // R3: writing 0 does nothing, writing 1 arms
        tag = "R3";
        wr(4, 8'h00);
        rd_chk("R3 zero write no arm", 4, 8'h00);
        @(negedge clk);
        arm_now();
        rd_chk("R3 pending set", 4, 8'h01);
        tag = "R4";
        @(negedge clk);
        rd_chk("R4 pending cleared by commit", 4, 8'h00);

        tag = "R5";
        idle(5);
        measure("R5 P=9 D=4", 4, 10);

        // R2: intermediate holding value without arm
        tag = "R2";
        wr(3, 8'h01);
        idle(30);
        measure("R2 unarmed rewrite", 4, 10);

        // R8: holding writes while pending
        tag = "R8";
        while (m_cnt != 16'd0) @(negedge clk);
        arm_now();
        wr(3, 8'h00); wr(2, 8'd7);
        rd_chk("R8 still pending", 4, 8'h01);
        idle(25);
        measure("R8 late writes committed", 7, 10);

        // R7: repeated re-arm with no change
        tag = "R7";
        for (int i = 0; i < 20; i++) begin
            wr(4, 8'h01);
            idle(2);
        end
        measure("R7 rearm no glitch", 7, 10);

        // R6: duty corners
        tag = "R6";
        wr(2, 8'd0); wr(4, 8'h01);
        idle(25);
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            check("R6 zero duty low", {15'd0, pwm_o}, 16'd0);
        end
        wr(2, 8'd20); wr(4, 8'h01);
        idle(25);
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            check("R6 duty over period high", {15'd0, pwm_o}, 16'd1);
        end
        wr(2, 8'd9); wr(4, 8'h01);
        idle(25);
        measure("R6 duty equals period", 9, 10);

        // R5: period using the high byte
        tag = "R5";
        wr(0, 8'h05); wr(1, 8'h01); wr(2, 8'h80); wr(3, 8'h00); wr(4, 8'h01);
        idle(600);
        measure("R5 P=261 D=128", 128, 262);

        // R9: request on the event cycle
        tag = "R9";
        wr(1, 8'd0); wr(0, 8'd9); wr(2, 8'd3); wr(4, 8'h01);
        idle(300);
        measure("R9 baseline", 3, 10);
        wr(2, 8'd6);
        while (m_cnt != m_aper) @(negedge clk);
        arm_now();
        rd_chk("R9 idle arm on event waits", 4, 8'h01);
        idle(12);
        rd_chk("R9 committed next event", 4, 8'h00);
        measure("R9 idle case duty", 6, 10);

        wr(2, 8'd2);
        while (m_cnt != 16'd0) @(negedge clk);
        arm_now();
        while (m_cnt != m_aper) @(negedge clk);
        arm_now();
        rd_chk("R9 commit and stay armed", 4, 8'h01);
        idle(12);
        rd_chk("R9 second commit clears", 4, 8'h00);
        measure("R9 armed case duty", 2, 10);

        idle(3);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule